// File: doc/BRIEF.md
# Polyphase Decimating Filter Bank Front-End

This block is the filtering stage that sits ahead of a 64-point streaming DFT in a 64-channel channelizer. Input samples arrive one at a time. Each accepted sample is steered to one of 64 branches in rotation, and each branch is an 8-tap FIR over that branch's own sample history. Taken as a whole, the bank decimates by 64: every branch produces one result per 64 input samples.

One set of eight multipliers serves every branch. On each accepted sample, the eight coefficients of the current branch are read in parallel from a coefficient store, which is organised as eight banks addressed by branch index. The branch's history is read from a per-tap addressable delay store. The eight products are registered. The next stage sums them, rounds and saturates the sum, and emits the result tagged with its branch index. With unbroken input, the output stream has one result per cycle. Results come in branch order, and a frame flag marks branch 0, so a streaming FFT can take the stream directly.

Coefficients are written one at a time through a simple write port. The port address is branch × 8 + tap.

Top module: `polyphase_bank_fe`

## Requirements
- R1: After reset, out_valid and out_frame_start are 0, the next accepted sample belongs to branch 0, and every branch's sample history reads as zero.
- R2: The n-th sample accepted since reset belongs to branch n mod 64. Its result leaves with out_valid high exactly two cycles after the sample is accepted, and out_phase carries that branch index.
- R3: out_frame_start is high exactly on the output cycles whose out_phase is 0, and is low whenever out_valid is low.
- R4: For a sample x0 accepted into branch p, the filter sum is acc = Σ h[p][t]·x_t over t = 0..7, where x_t is the sample that branch p accepted t visits earlier (x0 is the new sample) and positions before reset count as 0.
- R5: A write with coef_we high stores coef_data as h[p][t], with t = coef_addr[2:0] and p = coef_addr[8:3]. Coefficients are not cleared by reset.
- R6: With SHIFT = 15, out_data is floor((acc + 2^14) / 2^15), which rounds halves upward. For example, acc = 16384 gives 1, acc = 0 gives 0 and acc = 16383 gives 0.
- R7: The rounded value is clamped to the signed 16-bit range [-32768, 32767].
- R8: A cycle with in_valid low produces no output two cycles later, does not advance the branch rotation, and leaves every history unchanged.
- R9: Back-to-back valid input gives back-to-back valid output, one result per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 9 | Coefficient address, branch × 8 + tap |
| coef_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | Branch result valid |
| out_phase | output | 6 | Branch index of the result |
| out_frame_start | output | 1 | High with the branch 0 result |
| out_data | output | 16 | Rounded, saturated branch result |

## Verification
The bound checker looks at the timing and tagging on every cycle. It checks the two-cycle valid latency, that idle cycles produce no output, that branch indices step by one and wrap, that the frame flag lines up with branch 0, and that output is quiet after reset. The arithmetic cannot be checked this way, and only the bench scenarios show it. Those scenarios cover the per-branch 8-deep history, the coefficient bank addressing, rounding at the exact half-LSB boundary, saturation at both rails, and the requirement that idle cycles leave the histories untouched. The bench compares each result against a model that computes the sum directly from the requirements.

// File: rtl/polyphase_bank_fe.sv
module polyphase_bank_fe #(
  parameter int PHASES = 64,
  parameter int TAPS   = 8,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int OW     = 16,
  parameter int SHIFT  = 15
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic signed [DW-1:0]              in_sample,
  input  logic                              coef_we,
  input  logic [$clog2(PHASES*TAPS)-1:0]    coef_addr,
  input  logic signed [CW-1:0]              coef_data,
  output logic                              out_valid,
  output logic [$clog2(PHASES)-1:0]         out_phase,
  output logic                              out_frame_start,
  output logic signed [OW-1:0]              out_data
);
  localparam int PW  = $clog2(PHASES);
  localparam int TW  = $clog2(TAPS);
  localparam int AW  = PW + TW;
  localparam int PRW = DW + CW;
  localparam int ACW = PRW + TW + 1;
  localparam logic signed [ACW-1:0] HI   = ACW'(2**(OW-1) - 1);
  localparam logic signed [ACW-1:0] LO   = -ACW'(2**(OW-1));
  localparam logic signed [ACW-1:0] HALF = ACW'(1) <<< (SHIFT-1);

  logic [PW-1:0] phase;
  logic signed [DW-1:0]  tap  [TAPS];
  logic signed [CW-1:0]  crd  [TAPS];
  logic signed [PRW-1:0] prod [TAPS];
  logic          s1_valid;
  logic [PW-1:0] s1_phase;

  // branch rotation (R2, R8)
  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= '0;
    else if (in_valid) phase <= (phase == PW'(PHASES-1)) ? '0 : phase + 1'b1;
  end

  assign tap[0] = in_sample;

  genvar t;
  generate
    // per-tap delay store, addressed by branch index
    for (t = 0; t < TAPS-1; t++) begin : g_dly
      logic signed [DW-1:0] dl [PHASES];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int p = 0; p < PHASES; p++) dl[p] <= '0;
        end else if (in_valid) begin
          dl[phase] <= tap[t];
        end
      end
      assign tap[t+1] = dl[phase];
    end

    // coefficient banks: one bank per tap, row = branch
    for (t = 0; t < TAPS; t++) begin : g_coef
      logic signed [CW-1:0] cm [PHASES];
      always_ff @(posedge clk) begin
        if (coef_we && coef_addr[TW-1:0] == TW'(t))
          cm[coef_addr[AW-1:TW]] <= coef_data;
      end
      assign crd[t] = cm[phase];

      always_ff @(posedge clk) begin
        if (in_valid) prod[t] <= PRW'(tap[t]) * PRW'(crd[t]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_phase <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_phase <= phase;
    end
  end

  logic signed [ACW-1:0] acc, rnd, sat;
  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + ACW'(prod[i]);
    rnd = (acc + HALF) >>> SHIFT;
    if (rnd > HI)      sat = HI;
    else if (rnd < LO) sat = LO;
    else               sat = rnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_frame_start <= 1'b0;
      out_phase       <= '0;
      out_data        <= '0;
    end else begin
      out_valid       <= s1_valid;
      out_frame_start <= s1_valid && (s1_phase == '0);
      if (s1_valid) begin
        out_phase <= s1_phase;
        out_data  <= sat[OW-1:0];
      end
    end
  end
endmodule

module polyphase_bank_fe_chk #(
  parameter int PHASES = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic [$clog2(PHASES)-1:0] out_phase,
  input logic                      out_frame_start
);
  localparam int PW = $clog2(PHASES);
  logic [PW-1:0] nxt;

  always_ff @(posedge clk) begin
    if (!rst_n)         nxt <= '0;
    else if (out_valid) nxt <= (out_phase == PW'(PHASES-1)) ? '0 : out_phase + 1'b1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
  a_r2_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  a_r8_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_phase == nxt);
  a_r3_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_frame_start == (out_phase == '0)));
  a_r3_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_frame_start);
endmodule

bind polyphase_bank_fe polyphase_bank_fe_chk #(.PHASES(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_phase(out_phase), .out_frame_start(out_frame_start)
);

// File: tb/tb_polyphase_bank_fe.sv
module tb_polyphase_bank_fe;
  localparam int PH = 64, TP = 8;

  logic clk = 0, rst_n = 0, in_valid = 0, coef_we = 0;
  logic signed [15:0] in_sample = 0, coef_data = 0, out_data;
  logic [8:0] coef_addr = 0;
  logic out_valid, out_frame_start;
  logic [5:0] out_phase;

  polyphase_bank_fe dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  longint hist [PH][TP];
  longint coef [PH*TP];
  int mphase = 0;
  bit v1 = 0, v2 = 0;
  int p1, p2;
  longint d1, d2;
  string t1, t2;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model(int p, longint x);
    longint acc = 0, r;
    for (int t = TP-1; t > 0; t--) hist[p][t] = hist[p][t-1];
    hist[p][0] = x;
    for (int t = 0; t < TP; t++) acc += hist[p][t] * coef[p*TP + t];
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic step(bit iv, longint x, string tag, bit we = 0, int addr = 0, longint cd = 0);
    @(negedge clk);
    chk(out_valid == v2, v2 ? "R9" : "R8", out_valid, v2);
    if (v2 && out_valid) begin
      chk(out_phase == p2, "R2", out_phase, p2);
      chk(out_frame_start == (p2 == 0), "R3", out_frame_start, p2 == 0);
      chk(out_data == d2, t2, out_data, d2);
    end else begin
      chk(out_frame_start == 0, "R3", out_frame_start, 0);
    end
    in_valid = iv; in_sample = 16'(x);
    coef_we = we; coef_addr = 9'(addr); coef_data = 16'(cd);
    if (we) coef[addr] = cd;
    v2 = v1; p2 = p1; d2 = d1; t2 = t1;
    v1 = iv; t1 = tag;
    if (iv) begin
      p1 = mphase;
      d1 = model(mphase, x);
      mphase = (mphase + 1) % PH;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; coef_we = 0;
    @(negedge clk);
    rst_n = 1;
    for (int p = 0; p < PH; p++) for (int t = 0; t < TP; t++) hist[p][t] = 0;
    mphase = 0; v1 = 0; v2 = 0;
    for (int i = 0; i < 3; i++) step(0, 0, "R1");   // R1: quiet after reset
  endtask

  function automatic longint rnd_sample();
    seed = seed * 1103515245 + 12345;
    return longint'((seed >> 8) % 4001) - 2000;
  endfunction

  task automatic load_all(longint base, bit pattern);
    for (int a = 0; a < PH*TP; a++)
      step(0, 0, "R5", 1, a, pattern ? (longint'((a * 97 * 37) % 16001) - 8000) : base);
  endtask

  initial begin
    for (int a = 0; a < PH*TP; a++) coef[a] = 0;
    repeat (3) @(negedge clk);
    do_reset();

    // R4/R5: distinct coefficient per address, continuous stream over three frames
    load_all(0, 1);
    step(0, 0, "R4"); step(0, 0, "R4");
    for (int i = 0; i < 3*PH; i++) step(1, rnd_sample(), "R4");
    // R8: idle cycles interleaved, histories and rotation must hold
    for (int i = 0; i < 3*PH; i++) step(i % 3 != 2, rnd_sample(), "R8");
    for (int i = 0; i < 4; i++) step(0, 0, "R8");

    // R5: single coefficient at branch 3 tap 2 (addr 26), coefficients survive reset
    load_all(0, 0);
    step(0, 0, "R5", 1, 3*8 + 2, 16384);
    do_reset();
    for (int i = 0; i < 4*PH; i++) step(1, rnd_sample(), "R5");

    // R6: half-LSB rounding with h[0][0] = 1
    load_all(0, 0);
    step(0, 0, "R6", 1, 0, 1);
    do_reset();
    for (int f = 0; f < 3; f++)
      for (int p = 0; p < PH; p++)
        step(1, p != 0 ? rnd_sample() : (f == 0 ? 16384 : (f == 1 ? -16384 : 16383)), "R6");

    // R7: saturation at both rails
    load_all(32767, 0);
    do_reset();
    for (int i = 0; i < 2*PH; i++) step(1, 32767, "R7");
    for (int i = 0; i < 2*PH; i++) step(1, -32768, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, "R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule